// File: doc/BRIEF.md
# Interrupt Sense Normalizer

This block sits in front of an interrupt controller that accepts only active-high levels and rising edges. Each of up to 168 interrupt pins passes through a two-flop synchronizer and then a per-pin sense converter. The converter turns active-low levels into active-high levels. It turns falling edges into rising-edge pulses. In dual-edge mode, any change of the pin produces a rising-edge pulse. Active-high levels and rising edges pass through unchanged. Because of this, every sense type the pins can carry reaches the controller in a form it understands.

Software sets up the block through a 32-bit register bus with address, write enable, write data and read data. Reads are combinational. There are two register banks:
- a bank of enable words, one bit per pin;
- a bank of configuration words, one word per pin, holding a 3-bit sense code.

A pin that is disabled, or that holds a code outside the five defined ones, keeps its output low.

Top module: `irq_sense_norm`

## Requirements
- R1: After reset, every irq_o bit is low, every enable word reads zero and every configuration word reads zero.
- R2: Pin n's enable bit is bit n%32 of the word at byte address 0x10 + 4*(n/32). There are ceil(168/32) enable words. Bits that map to no pin read zero.
- R3: Pin n's configuration word is at byte address 0x110 + 4*n. Only bits [2:0] are stored, and bits [31:3] read zero. Addresses outside both banks read zero, and writes to them change no state.
- R4: With sense code 3'b100 (level, active high) and the pin enabled, irq_o[n] equals the value irq_i[n] had three rising clock edges earlier.
- R5: With sense code 3'b000 (level, active low) and the pin enabled, irq_o[n] is the inverse of the value irq_i[n] had three rising clock edges earlier.
- R6: With sense code 3'b110 (rising edge), each 0-to-1 change of irq_i[n] gives exactly one single-cycle high pulse, three edges later. A 1-to-0 change gives none.
- R7: With sense code 3'b010 (falling edge), each 1-to-0 change of irq_i[n] gives exactly one single-cycle high pulse. A 0-to-1 change gives none.
- R8: With sense code 3'b111 (both edges), every change of irq_i[n] in either direction gives exactly one single-cycle high pulse.
- R9: A pin whose enable bit is clear drives irq_o[n] low, whatever its input and code. An enabled pin holding code 3'b001, 3'b011 or 3'b101 also drives irq_o[n] low.
- R10: A write to pin n's configuration word forces irq_o[n] low in the following cycle. Edge detection then resumes from the current synchronized level, so a write while the input is steady produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 168 | Raw interrupt pins, asynchronous |
| reg_addr_i | input | 12 | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 168 | Normalized interrupts toward the controller |

## Verification
The active-high and active-low level modes are driven with toggling inputs. These runs show whether a lane inverts or passes its input, and check the three-edge latency. The edge modes each get a rise and a fall inside a counting window. A single pulse count per direction tells the rising, falling and dual-edge codes apart, and also exposes pulses longer than one cycle. A dual-edge run with two closely spaced transitions shows that both produce pulses. Further runs use disabled pins, unlisted codes, configuration rewrites under a steady input, and the last pin together with the partial last enable word. These cover the gating, the history reset and the bank boundaries.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  typedef enum logic [2:0] {
    SENSE_LVL_LO = 3'b000,
    SENSE_FALL   = 3'b010,
    SENSE_LVL_HI = 3'b100,
    SENSE_RISE   = 3'b110,
    SENSE_BOTH   = 3'b111
  } sense_e;
endpackage

// File: rtl/irq_sense_sync.sv
module irq_sense_sync #(
  parameter int WIDTH  = 168,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs #(
  parameter int NUM_PINS = 168,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int EN_BASE  = 'h10,
  parameter int CFG_BASE = 'h110
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     we_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [NUM_PINS-1:0]      en_o,
  output logic [NUM_PINS-1:0][2:0] cfg_o,
  output logic [NUM_PINS-1:0]      cfg_wr_o
);
  localparam int EN_WORDS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int IDX_W    = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] EN_HI  = ADDR_W'(EN_BASE + 4 * EN_WORDS);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 4 * NUM_PINS);

  logic [NUM_PINS-1:0]        en_q;
  logic [NUM_PINS-1:0][2:0]   cfg_q;
  logic [ADDR_W-1:0]          en_off, cfg_off;
  logic [IDX_W-1:0]           en_idx, cfg_idx;
  logic                       en_hit, cfg_hit;
  logic [EN_WORDS-1:0]        en_wsel;
  logic [EN_WORDS*DATA_W-1:0] en_pad;
  logic                       unused_lsb;

  assign en_off     = addr_i - EN_LO;
  assign cfg_off    = addr_i - CFG_LO;
  assign en_idx     = en_off[ADDR_W-1:2];
  assign cfg_idx    = cfg_off[ADDR_W-1:2];
  assign en_hit     = (addr_i >= EN_LO) && (addr_i < EN_HI);
  assign cfg_hit    = (addr_i >= CFG_LO) && (addr_i < CFG_HI);
  assign unused_lsb = ^{en_off[1:0], cfg_off[1:0]};
  assign en_pad     = (EN_WORDS*DATA_W)'(en_q);

  always_comb begin
    for (int k = 0; k < EN_WORDS; k++)
      en_wsel[k] = we_i && en_hit && (en_idx == IDX_W'(k));
    for (int n = 0; n < NUM_PINS; n++)
      cfg_wr_o[n] = we_i && cfg_hit && (cfg_idx == IDX_W'(n));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (en_wsel[n / DATA_W]) en_q[n] <= wdata_i[n % DATA_W];
        if (cfg_wr_o[n])         cfg_q[n] <= wdata_i[2:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < EN_WORDS; k++)
      if (en_hit && en_idx == IDX_W'(k)) rdata_o = en_pad[k*DATA_W +: DATA_W];
    for (int n = 0; n < NUM_PINS; n++)
      if (cfg_hit && cfg_idx == IDX_W'(n)) rdata_o = DATA_W'(cfg_q[n]);
  end

  assign en_o  = en_q;
  assign cfg_o = cfg_q;

  p_cfg_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_hit |-> (rdata_o[DATA_W-1:3] == '0));
  p_miss_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_hit && !en_hit) |-> (rdata_o == '0));
  p_miss_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !cfg_hit && !en_hit) |=> ($stable(en_q) && $stable(cfg_q)));
endmodule

// File: rtl/irq_sense_lane.sv
module irq_sense_lane
  import irq_sense_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic       en_i,
  input  logic [2:0] cfg_i,
  input  logic       cfg_wr_i,
  output logic       irq_o
);
  logic prev_q, irq_q, rise, fall, hit;

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  always_comb begin
    case (cfg_i)
      SENSE_LVL_LO: hit = ~sync_i;
      SENSE_LVL_HI: hit = sync_i;
      SENSE_RISE:   hit = rise;
      SENSE_FALL:   hit = fall;
      SENSE_BOTH:   hit = rise | fall;
      default:      hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      irq_q  <= cfg_wr_i ? 1'b0 : (en_i & hit);
    end
  end

  assign irq_o = irq_q;

  p_disabled_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !irq_o);
  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && (cfg_i == SENSE_RISE || cfg_i == SENSE_FALL)) |=> !irq_o);
  p_level_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cfg_i == SENSE_LVL_HI && !cfg_wr_i) |=> (irq_o == $past(sync_i)));
  p_level_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cfg_i == SENSE_LVL_LO && !cfg_wr_i) |=> (irq_o != $past(sync_i)));
  p_wr_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> !irq_o);
endmodule

// File: rtl/irq_sense_norm.sv
module irq_sense_norm #(
  parameter int NUM_PINS = 168,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int EN_BASE  = 'h10,
  parameter int CFG_BASE = 'h110,
  parameter int SYNC_STG = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [NUM_PINS-1:0] irq_o
);
  logic [NUM_PINS-1:0]      sync;
  logic [NUM_PINS-1:0]      en;
  logic [NUM_PINS-1:0][2:0] cfg;
  logic [NUM_PINS-1:0]      cfg_wr;

  irq_sense_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (sync)
  );

  irq_sense_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .EN_BASE(EN_BASE), .CFG_BASE(CFG_BASE)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (en),
    .cfg_o   (cfg),
    .cfg_wr_o(cfg_wr)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_lane
    irq_sense_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync[n]),
      .en_i    (en[n]),
      .cfg_i   (cfg[n]),
      .cfg_wr_i(cfg_wr[n]),
      .irq_o   (irq_o[n])
    );
  end
endmodule

// File: tb/irq_sense_norm_tb_top.sv
module irq_sense_norm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 168;
  localparam logic [11:0] EN_B  = 12'h010;
  localparam logic [11:0] CFG_B = 12'h110;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] irq_i = '0;
  logic [11:0]   reg_addr_i = '0;
  logic          reg_we_i = 1'b0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [NP-1:0] irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [5:0][31:0] en_sh = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_sense_norm dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i),
    .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic set_en(int p, bit v);
    en_sh[p/32][p%32] = v;
    wr(EN_B + 12'(4*(p/32)), en_sh[p/32]);
  endtask

  task automatic set_cfg(int p, logic [2:0] c);
    wr(CFG_B + 12'(4*p), {29'b0, c});
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // drive pin at a negedge, then count high samples over the next n negedges
  task automatic drive_count(int p, bit v, int n, output int c);
    @(negedge clk_i);
    irq_i[p] = v;
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      c += int'(irq_o[p]);
    end
  endtask

  task automatic prep(int p, bit lvl, logic [2:0] c);
    @(negedge clk_i);
    irq_i[p] = lvl;
    set_cfg(p, c);
    set_en(p, 1'b1);
    wait_cyc(5);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_o after reset", 32'(irq_o != '0), 0);
    for (int k = 0; k < 6; k++) begin
      rd(EN_B + 12'(4*k), d);
      check("R1 enable word", d, 0);
    end
    rd(CFG_B, d);               check("R1 cfg pin0", d, 0);
    rd(CFG_B + 12'(4*167), d);  check("R1 cfg pin167", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(EN_B, 32'hFFFF_FFFF);
    rd(EN_B, d);               check("R2 enable word0 readback", d, 32'hFFFF_FFFF);
    wr(EN_B, 32'h0);
    wr(EN_B + 12'h014, 32'hFFFF_FFFF);
    rd(EN_B + 12'h014, d);     check("R2 last enable word partial", d, 32'h0000_00FF);
    wr(EN_B + 12'h014, 32'h0);
    wr(CFG_B + 12'(4*167), 32'hFFFF_FFF6);
    rd(CFG_B + 12'(4*167), d); check("R3 cfg upper bits zero", d, 32'h6);
    set_cfg(0, 3'b010);
    wr(12'h3B0, 32'hFFFF_FFFF);
    rd(12'h3B0, d);            check("R3 past cfg bank reads zero", d, 0);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, d);            check("R3 below banks reads zero", d, 0);
    rd(CFG_B, d);              check("R3 unmapped write no effect on pin0", d, 32'h2);
    rd(EN_B, d);               check("R3 unmapped write no effect on enables", d, 0);
    set_cfg(0, 3'b000);
    set_cfg(167, 3'b000);
  endtask

  task automatic t_level_hi();
    prep(3, 1'b0, 3'b100);
    check("R4 level high idle", 32'(irq_o[3]), 0);
    @(negedge clk_i); irq_i[3] = 1'b1;
    wait_cyc(2); check("R4 not yet after two edges", 32'(irq_o[3]), 0);
    wait_cyc(1); check("R4 high after three edges", 32'(irq_o[3]), 1);
    wait_cyc(4); check("R4 stays high", 32'(irq_o[3]), 1);
    @(negedge clk_i); irq_i[3] = 1'b0;
    wait_cyc(3); check("R4 follows low", 32'(irq_o[3]), 0);
    // last pin, partial enable word
    prep(167, 1'b1, 3'b100);
    check("R4 R2 pin167 level high", 32'(irq_o[167]), 1);
    set_en(167, 1'b0);
    wait_cyc(2); check("R9 pin167 disabled", 32'(irq_o[167]), 0);
  endtask

  task automatic t_level_lo();
    prep(4, 1'b0, 3'b000);
    check("R5 active low idle input low", 32'(irq_o[4]), 1);
    @(negedge clk_i); irq_i[4] = 1'b1;
    wait_cyc(3); check("R5 input high gives low", 32'(irq_o[4]), 0);
  endtask

  task automatic t_edges();
    int c;
    prep(5, 1'b0, 3'b110);
    drive_count(5, 1'b1, 8, c); check("R6 rise gives one pulse", c, 1);
    drive_count(5, 1'b0, 8, c); check("R6 fall gives none", c, 0);
    prep(6, 1'b1, 3'b010);
    drive_count(6, 1'b0, 8, c); check("R7 fall gives one pulse", c, 1);
    drive_count(6, 1'b1, 8, c); check("R7 rise gives none", c, 0);
    prep(7, 1'b0, 3'b111);
    drive_count(7, 1'b1, 8, c); check("R8 rise gives one pulse", c, 1);
    drive_count(7, 1'b0, 8, c); check("R8 fall gives one pulse", c, 1);
    // two transitions three cycles apart
    c = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      c += int'(irq_o[7]);
      if (i == 0) irq_i[7] = 1'b1;
      if (i == 3) irq_i[7] = 1'b0;
    end
    check("R8 two close transitions give two pulses", c, 2);
  endtask

  task automatic t_disable();
    @(negedge clk_i); irq_i[8] = 1'b0;
    set_cfg(8, 3'b000);
    wait_cyc(5); check("R9 disabled active-low pin stays low", 32'(irq_o[8]), 0);
    set_en(8, 1'b1);
    wait_cyc(2); check("R9 enabled pin goes high", 32'(irq_o[8]), 1);
    set_en(8, 1'b0);
    wait_cyc(2); check("R9 disable drops output", 32'(irq_o[8]), 0);
    prep(10, 1'b1, 3'b001);
    check("R9 code 001 low", 32'(irq_o[10]), 0);
    set_cfg(10, 3'b101);
    wait_cyc(3); check("R9 code 101 low", 32'(irq_o[10]), 0);
    set_cfg(10, 3'b011);
    wait_cyc(3); check("R9 code 011 low", 32'(irq_o[10]), 0);
  endtask

  task automatic t_cfg_write();
    int c;
    prep(9, 1'b1, 3'b100);
    check("R10 level high before rewrite", 32'(irq_o[9]), 1);
    @(negedge clk_i);
    reg_addr_i = CFG_B + 12'(4*9); reg_wdata_i = 32'h6; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    check("R10 output low after cfg write", 32'(irq_o[9]), 0);
    c = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      c += int'(irq_o[9]);
    end
    check("R10 steady input no pulse", c, 0);
    prep(11, 1'b0, 3'b111);
    set_cfg(11, 3'b110);
    c = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      c += int'(irq_o[11]);
    end
    check("R10 edge mode rewrite no pulse", c, 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);
    t_reset();
    t_regs();
    t_level_hi();
    t_level_lo();
    t_edges();
    t_disable();
    t_cfg_write();
    wait_cyc(2);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule